// File: doc/BRIEF.md
# Register-Mapped EDID Read Controller

This block puts a display I2C controller's register front end over a local EDID store, with no physical bus behind it. Driver software programs it as it would a real I2C engine. It picks a connector with the pin-select register and writes a command word that names the target, the start index, the byte count and the cycle type. It then pulls monitor-identification bytes from the data register, up to four at a time. The status register mirrors the handshake bits that the driver polls.

Inside, the command word becomes a byte stream out of a 256-byte store. The stream is gated by three things: whether the EDID target was addressed, whether a non-DisplayPort monitor was present on the chosen port when the pin was selected, and whether the read pointer is still inside the store. A small phase machine tracks idle, data and wait. The store is filled through a plain byte-write load port. The register bus takes one access per cycle, and read data is registered one cycle after the request.

Top module: `edid_i2c_regs`

## Requirements
- R1: After reset, every register reads 0 and `bus_phase` is idle (encoding: idle 0, data 1, wait 2).
- R2: A pin-select write (offset 0x0) clears the transfer state. A pin code 1..NPORT maps to port code-1. For a mapped code, the phase goes idle, ACTIVE (status bit 9) clears, and HW_READY (bit 11) and WAIT_PHASE (bit 14) set. ACK_ERR (bit 10) clears when a monitor is present and not DisplayPort on that port, and sets otherwise. Code 0 or a code above NPORT leaves status and phase unchanged.
- R3: A status read (offset 0x8) returns the status before the read, then sets IN_USE (bit 15). Writing 1 to bit 15 clears IN_USE. Writes leave all other status bits unchanged.
- R4: A command write (offset 0x4, bit 31 not stored) whose cycle field (bits 27:25) is 1, 3, 5 or 7 sets the phase to data and sets ACTIVE. Fields 0, 2 and 6 leave the phase unchanged.
- R5: Cycle field 4 (stop) returns the phase to idle, clears ACTIVE and clears the transfer state, but only when the previously stored command's cycle field is nonzero. Otherwise it has no effect on the phase.
- R6: The command loads the 9-bit total count from bits 24:16. When bit 26 is set, it loads the read pointer from bits 15:8. A data read (offset 0xC) with direction bit 0 set returns min(4, total − pointer) bytes, the first in bits 7:0 and the rest in successively higher bytes. Bytes not returned keep their previous data-register value.
- R7: When a data read finds 4 or fewer bytes left, the phase becomes idle if the stored cycle is 5 or 7, and wait otherwise. The transfer state clears.
- R8: When total ≤ pointer, or direction bit 0 is clear, a data read returns the stored data value unchanged and does not advance the pointer.
- R9: A byte is fetched, and the pointer advanced, only when the command addressed target 0x50 (bits 7:1), EDID is available from a pin selection, and the pointer is below 256. Otherwise the byte is 0. Other nonzero target addresses are ignored.
- R10: A command write with bit 31 set sets HW_READY. While bit 31 is stored, further command writes with bit 31 set are ignored. One with bit 31 clear clears the stored bit 31 and sets status to HW_READY, plus ACK_ERR when no EDID is available. It also sets the phase to idle.
- R11: Command bit 30 (software ready) is never stored, and it reads back as 0.
- R12: Writes to the data register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| rom_we | input | 1 | EDID store byte write |
| rom_addr | input | 8 | EDID store write index |
| rom_wdata | input | 8 | EDID store write byte |
| mon_present | input | NPORT | Monitor attached, one bit per port |
| mon_is_dp | input | NPORT | Attached monitor is DisplayPort, one bit per port |
| bus_phase | output | 2 | Current bus phase |

## Verification
A wrong pointer or count shows up on the very next data-register read: the bytes are shifted, or zero where store contents were due. A wrong phase or ACTIVE update appears on `bus_phase` one cycle after the offending write, and on the next status read. Stale availability or selection flags only show once a read reaches them, so the random mix interleaves pin changes, stops and clear-interrupt writes between data reads. A reference model compares every read and the phase after each access.

// File: rtl/edid_i2c_pkg.sv
package edid_i2c_pkg;

    localparam int BUS_W   = 32;
    localparam int LANES   = BUS_W / 8;
    localparam int CNT_W   = 9;
    localparam int IDX_W   = 8;
    localparam int ADV_W   = $clog2(LANES + 1);

    localparam logic [3:0] OFS_PIN  = 4'h0;
    localparam logic [3:0] OFS_CMD  = 4'h4;
    localparam logic [3:0] OFS_STAT = 4'h8;
    localparam logic [3:0] OFS_DATA = 4'hC;

    localparam logic [6:0] EDID_TARGET = 7'h50;

    localparam int ST_ACTIVE = 9;
    localparam int ST_ACKERR = 10;
    localparam int ST_HWRDY  = 11;
    localparam int ST_WAIT   = 14;
    localparam int ST_INUSE  = 15;

    localparam int CM_DIR    = 0;
    localparam int CM_INDEX  = 26;
    localparam int CM_SWRDY  = 30;
    localparam int CM_CLRINT = 31;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        CY_NONE      = 3'd0,
        CY_NIDX_WAIT = 3'd1,
        CY_RSV2      = 3'd2,
        CY_IDX_WAIT  = 3'd3,
        CY_STOP      = 3'd4,
        CY_NIDX_STOP = 3'd5,
        CY_RSV6      = 3'd6,
        CY_IDX_STOP  = 3'd7
    } cycle_e;

    typedef struct packed {
        logic in_use;
        logic wait_ph;
        logic hw_rdy;
        logic ack_err;
        logic active;
    } status_t;

    typedef struct packed {
        logic             sel;
        logic             avail;
        logic [CNT_W-1:0] ptr;
        logic [CNT_W-1:0] total;
        cycle_e           cyc;
    } xfer_t;

    localparam xfer_t XFER_CLEAR = '{sel: 1'b0, avail: 1'b0, ptr: '0, total: '0, cyc: CY_NONE};

    function automatic logic [BUS_W-1:0] status_word(status_t s);
        logic [BUS_W-1:0] w;
        w            = '0;
        w[ST_ACTIVE] = s.active;
        w[ST_ACKERR] = s.ack_err;
        w[ST_HWRDY]  = s.hw_rdy;
        w[ST_WAIT]   = s.wait_ph;
        w[ST_INUSE]  = s.in_use;
        return w;
    endfunction

    function automatic logic cyc_reads(cycle_e c);
        return c inside {CY_NIDX_WAIT, CY_IDX_WAIT, CY_NIDX_STOP, CY_IDX_STOP};
    endfunction

    function automatic logic cyc_stops(cycle_e c);
        return c inside {CY_NIDX_STOP, CY_IDX_STOP};
    endfunction

endpackage

// File: rtl/edid_store.sv
module edid_store #(
    parameter int DEPTH = 256,
    parameter int LANES = 4,
    parameter int PW    = 9
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [7:0]               wdata,
    input  logic [PW-1:0]            rd_base,
    output logic [LANES*8-1:0]       lane_byte,
    output logic [LANES-1:0]         lane_in
);
    localparam int AW = $clog2(DEPTH);
    localparam int XW = PW + 2;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [XW-1:0] idx;
        assign idx = XW'(rd_base) + XW'(g);
        assign lane_in[g] = idx < XW'(DEPTH);
        assign lane_byte[g*8 +: 8] = mem[idx[AW-1:0]];
    end
endmodule

// File: rtl/edid_pack.sv
module edid_pack
    import edid_i2c_pkg::*;
(
    input  logic [CNT_W-1:0]   ptr,
    input  logic [CNT_W-1:0]   total,
    input  logic               enable,
    input  logic [LANES*8-1:0] lane_byte,
    input  logic [LANES-1:0]   lane_in,
    input  logic [BUS_W-1:0]   old_data,
    output logic               has_left,
    output logic               last,
    output logic [BUS_W-1:0]   new_data,
    output logic [ADV_W-1:0]   advance
);
    localparam int DW = CNT_W + 1;

    logic [LANES-1:0] take;
    logic [LANES-1:0] fetch;

    assign has_left = total > ptr;
    assign last     = has_left && ((DW'(total) - DW'(ptr)) <= DW'(LANES));

    for (genvar g = 0; g < LANES; g++) begin : g_pack
        assign take[g]  = (DW'(ptr) + DW'(g)) < DW'(total);
        assign fetch[g] = take[g] && enable && lane_in[g];
        assign new_data[g*8 +: 8] = !take[g] ? old_data[g*8 +: 8]
                                  : (fetch[g] ? lane_byte[g*8 +: 8] : 8'h00);
    end

    always_comb begin
        advance = '0;
        for (int i = 0; i < LANES; i++) advance = advance + ADV_W'(fetch[i]);
    end
endmodule

// File: rtl/edid_i2c_regs.sv
module edid_i2c_regs
    import edid_i2c_pkg::*;
#(
    parameter int NPORT      = 4,
    parameter int EDID_DEPTH = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [3:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             rom_we,
    input  logic [7:0]       rom_addr,
    input  logic [7:0]       rom_wdata,
    input  logic [NPORT-1:0] mon_present,
    input  logic [NPORT-1:0] mon_is_dp,
    output logic [1:0]       bus_phase
);
    localparam int AW = $clog2(EDID_DEPTH);

    phase_e            phase_q;
    status_t           st_q;
    xfer_t             xf_q;
    logic [BUS_W-1:0]  pin_q;
    logic [BUS_W-1:0]  cmd_q;
    logic [BUS_W-1:0]  data_q;

    logic [LANES*8-1:0] lane_byte;
    logic [LANES-1:0]   lane_in;
    logic               has_left;
    logic               last;
    logic [BUS_W-1:0]   pk_data;
    logic [ADV_W-1:0]   adv;
    logic               pin_hit;
    logic               mon_ok;
    cycle_e             wcyc;
    cycle_e             old_cyc;

    edid_store #(.DEPTH(EDID_DEPTH), .LANES(LANES), .PW(CNT_W)) u_store (
        .clk      (clk),
        .we       (rom_we),
        .waddr    (rom_addr[AW-1:0]),
        .wdata    (rom_wdata),
        .rd_base  (xf_q.ptr),
        .lane_byte(lane_byte),
        .lane_in  (lane_in)
    );

    edid_pack u_pack (
        .ptr      (xf_q.ptr),
        .total    (xf_q.total),
        .enable   (xf_q.sel && xf_q.avail),
        .lane_byte(lane_byte),
        .lane_in  (lane_in),
        .old_data (data_q),
        .has_left (has_left),
        .last     (last),
        .new_data (pk_data),
        .advance  (adv)
    );

    assign wcyc    = cycle_e'(bus_wdata[27:25]);
    assign old_cyc = cycle_e'(cmd_q[27:25]);

    always_comb begin
        pin_hit = 1'b0;
        mon_ok  = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            if (32'(bus_wdata[2:0]) == p + 1) begin
                pin_hit = 1'b1;
                mon_ok  = mon_present[p] && !mon_is_dp[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            st_q      <= '0;
            xf_q      <= XFER_CLEAR;
            pin_q     <= '0;
            cmd_q     <= '0;
            data_q    <= '0;
            bus_rdata <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                OFS_PIN: begin
                    pin_q <= bus_wdata;
                    xf_q  <= XFER_CLEAR;
                    if (pin_hit) begin
                        phase_q      <= PH_IDLE;
                        st_q.active  <= 1'b0;
                        st_q.hw_rdy  <= 1'b1;
                        st_q.wait_ph <= 1'b1;
                        st_q.ack_err <= !mon_ok;
                        xf_q.avail   <= mon_ok;
                    end
                end
                OFS_CMD: begin
                    if (cmd_q[CM_CLRINT]) begin
                        if (!bus_wdata[CM_CLRINT]) begin
                            cmd_q[CM_CLRINT] <= 1'b0;
                            st_q             <= '0;
                            st_q.hw_rdy      <= 1'b1;
                            st_q.ack_err     <= !xf_q.avail;
                            phase_q          <= PH_IDLE;
                        end
                    end else begin
                        if (bus_wdata[CM_CLRINT]) st_q.hw_rdy <= 1'b1;
                        xf_q.total <= bus_wdata[24:16];
                        xf_q.cyc   <= wcyc;
                        if (bus_wdata[7:1] == EDID_TARGET) xf_q.sel <= 1'b1;
                        if (bus_wdata[CM_INDEX]) xf_q.ptr <= CNT_W'(bus_wdata[15:8]);
                        if (wcyc == CY_STOP) begin
                            if (old_cyc != CY_NONE) begin
                                xf_q        <= XFER_CLEAR;
                                phase_q     <= PH_IDLE;
                                st_q.active <= 1'b0;
                            end
                        end else if (cyc_reads(wcyc)) begin
                            phase_q     <= PH_DATA;
                            st_q.active <= 1'b1;
                        end
                        cmd_q <= bus_wdata & ~(32'h1 << CM_SWRDY);
                    end
                end
                OFS_STAT: begin
                    if (bus_wdata[ST_INUSE]) st_q.in_use <= 1'b0;
                end
                default: ;
            endcase
        end else if (bus_rd) begin
            unique case (bus_addr)
                OFS_PIN:  bus_rdata <= pin_q;
                OFS_CMD:  bus_rdata <= cmd_q;
                OFS_STAT: begin
                    bus_rdata   <= status_word(st_q);
                    st_q.in_use <= 1'b1;
                end
                OFS_DATA: begin
                    if (cmd_q[CM_DIR] && has_left) begin
                        data_q    <= pk_data;
                        bus_rdata <= pk_data;
                        xf_q.ptr  <= xf_q.ptr + CNT_W'(adv);
                        if (last) begin
                            phase_q <= cyc_stops(xf_q.cyc) ? PH_IDLE : PH_WAIT;
                            xf_q    <= XFER_CLEAR;
                        end
                    end else begin
                        bus_rdata <= data_q;
                    end
                end
                default: bus_rdata <= '0;
            endcase
        end
    end

    assign bus_phase = phase_q;

    AST_READ_CYCLE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CMD && !cmd_q[CM_CLRINT] && cyc_reads(wcyc))
        |=> (bus_phase == PH_DATA && st_q.active)); // R4

    AST_INUSE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == OFS_STAT) |=> bus_rdata[ST_INUSE] == $past(st_q.in_use) && st_q.in_use); // R3

    AST_SWRDY_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == OFS_CMD) |=> !bus_rdata[CM_SWRDY]); // R11

    AST_NO_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == OFS_DATA && !cmd_q[CM_DIR])
        |=> ($stable(xf_q.ptr) && bus_rdata == data_q)); // R8

    AST_CLRINT_RESET: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CMD && cmd_q[CM_CLRINT] && !bus_wdata[CM_CLRINT])
        |=> (bus_phase == PH_IDLE && st_q.hw_rdy && !st_q.active && !cmd_q[CM_CLRINT])); // R10

    AST_PTR_IN_STORE: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == OFS_DATA && $past(1'b1)) |=> xf_q.ptr <= CNT_W'(EDID_DEPTH)); // R9
endmodule

// File: tb/edid_i2c_regs_test.sv
module edid_i2c_regs_test;
    localparam int NPORT = 4;
    localparam logic [3:0] A_PIN = 4'h0, A_CMD = 4'h4, A_STAT = 4'h8, A_DATA = 4'hC;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]       bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic             rom_we = 1'b0;
    logic [7:0]       rom_addr = '0, rom_wdata = '0;
    logic [NPORT-1:0] mon_present = '0, mon_is_dp = '0;
    logic [1:0]       bus_phase;

    always #5 clk = ~clk;

    edid_i2c_regs #(.NPORT(NPORT), .EDID_DEPTH(256)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rom_we(rom_we), .rom_addr(rom_addr),
        .rom_wdata(rom_wdata), .mon_present(mon_present), .mon_is_dp(mon_is_dp), .bus_phase(bus_phase)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // reference model state
    logic [7:0]  edid [256];
    int          m_phase;
    bit          m_active, m_ack, m_hw, m_wait, m_inuse;
    bit          m_sel, m_avail;
    int          m_ptr, m_total, m_cyc;
    logic [31:0] m_pin, m_cmd, m_data;

    function automatic logic [7:0] rom_val(int i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    function automatic logic [31:0] m_status();
        logic [31:0] w = '0;
        w[9] = m_active; w[10] = m_ack; w[11] = m_hw; w[14] = m_wait; w[15] = m_inuse;
        return w;
    endfunction

    task automatic m_clear();
        m_sel = 0; m_avail = 0; m_ptr = 0; m_total = 0; m_cyc = 0;
    endtask

    task automatic m_reset();
        m_phase = 0; m_active = 0; m_ack = 0; m_hw = 0; m_wait = 0; m_inuse = 0;
        m_clear(); m_pin = '0; m_cmd = '0; m_data = '0;
    endtask

    task automatic m_write(logic [3:0] a, logic [31:0] d);
        int pin, cyc;
        case (a)
            A_PIN: begin
                m_pin = d; m_clear(); pin = int'(d[2:0]);
                if (pin != 0 && pin <= NPORT) begin
                    m_phase = 0; m_active = 0; m_hw = 1; m_wait = 1;
                    if (mon_present[pin-1] && !mon_is_dp[pin-1]) begin m_avail = 1; m_ack = 0; end
                    else m_ack = 1;
                end
            end
            A_CMD: begin
                if (m_cmd[31]) begin
                    if (!d[31]) begin
                        m_cmd[31] = 0; m_active = 0; m_wait = 0; m_inuse = 0;
                        m_hw = 1; m_ack = !m_avail; m_phase = 0;
                    end
                end else begin
                    cyc = int'(d[27:25]);
                    if (d[31]) m_hw = 1;
                    m_total = int'(d[24:16]); m_cyc = cyc;
                    if (d[7:1] == 7'h50) m_sel = 1;
                    if (d[26]) m_ptr = int'(d[15:8]);
                    if (cyc == 4) begin
                        if (m_cmd[27:25] != 3'd0) begin m_clear(); m_phase = 0; m_active = 0; end
                    end else if (cyc == 1 || cyc == 3 || cyc == 5 || cyc == 7) begin
                        m_phase = 1; m_active = 1;
                    end
                    m_cmd = d; m_cmd[30] = 1'b0;
                end
            end
            A_STAT: if (d[15]) m_inuse = 0;
            default: ;
        endcase
    endtask

    task automatic m_read(logic [3:0] a, output logic [31:0] v);
        int left, n, p;
        case (a)
            A_PIN: v = m_pin;
            A_CMD: v = m_cmd;
            A_STAT: begin v = m_status(); m_inuse = 1; end
            A_DATA: begin
                if (m_cmd[0] && m_total > m_ptr) begin
                    left = m_total - m_ptr; n = (left > 4) ? 4 : left;
                    v = m_data; p = m_ptr;
                    for (int i = 0; i < n; i++) begin
                        if (m_sel && m_avail && p < 256) begin v[i*8 +: 8] = edid[p]; p++; end
                        else v[i*8 +: 8] = 8'h00;
                    end
                    m_ptr = p; m_data = v;
                    if (left <= 4) begin
                        m_phase = (m_cyc == 5 || m_cyc == 7) ? 0 : 2;
                        m_clear();
                    end
                end else v = m_data;
            end
            default: v = '0;
        endcase
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d, string req);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
        m_write(a, d);
        check(req, 32'(bus_phase), 32'(m_phase));
    endtask

    task automatic rd(logic [3:0] a, string req);
        logic [31:0] e;
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        m_read(a, e);
        check(req, bus_rdata, e);
        check(req, 32'(bus_phase), 32'(m_phase));
    endtask

    function automatic logic [31:0] cmd(bit clr, bit swr, int cyc, logic [6:0] tgt, int idx, int total, bit dir);
        logic [31:0] w = '0;
        w[31] = clr; w[30] = swr; w[27:25] = 3'(cyc); w[24:16] = 9'(total);
        w[15:8] = 8'(idx); w[7:1] = tgt; w[0] = dir;
        return w;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20241));
        m_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        for (int i = 0; i < 256; i++) begin
            rom_we = 1; rom_addr = 8'(i); rom_wdata = rom_val(i); edid[i] = rom_val(i);
            @(negedge clk);
        end
        rom_we = 0;

        // R1: reset state
        check("R1", 32'(bus_phase), 32'd0);
        rd(A_PIN, "R1"); rd(A_CMD, "R1"); rd(A_DATA, "R1"); rd(A_STAT, "R1");
        // R3: in-use set by read, write 1 clears, other bits ignore writes
        rd(A_STAT, "R3");
        wr(A_STAT, 32'hFFFF_7FFF, "R3"); rd(A_STAT, "R3");
        wr(A_STAT, 32'h0000_8000, "R3"); rd(A_STAT, "R3");
        // R10: clear-interrupt handshake
        wr(A_CMD, 32'h8000_0000, "R10"); rd(A_STAT, "R10");
        wr(A_CMD, cmd(1, 0, 7, 7'h50, 3, 20, 1), "R10"); rd(A_CMD, "R10");
        wr(A_CMD, 32'h0, "R10"); rd(A_STAT, "R10"); rd(A_CMD, "R10");
        // R2: pin selection outcomes
        mon_present = 4'b0101; mon_is_dp = 4'b0100;
        wr(A_PIN, 32'h1, "R2"); rd(A_STAT, "R2");
        wr(A_PIN, 32'h3, "R2"); rd(A_STAT, "R2");
        wr(A_PIN, 32'h2, "R2"); rd(A_STAT, "R2");
        wr(A_PIN, 32'h0, "R2"); rd(A_STAT, "R2");
        wr(A_PIN, 32'h6, "R2"); rd(A_STAT, "R2"); rd(A_PIN, "R2");
        // R4/R6/R7: indexed read with stop, 10 bytes from 0x10
        wr(A_PIN, 32'h1, "R2");
        wr(A_CMD, cmd(0, 1, 7, 7'h50, 8'h10, 8'h1A, 1), "R4");
        rd(A_CMD, "R11");
        rd(A_DATA, "R6"); rd(A_DATA, "R6"); rd(A_STAT, "R4");
        rd(A_DATA, "R7"); rd(A_DATA, "R8");
        // R7: no-stop variant ends in wait
        wr(A_PIN, 32'h1, "R2");
        wr(A_CMD, cmd(0, 0, 1, 7'h50, 0, 3, 1), "R4");
        rd(A_DATA, "R7");
        // R5: stop after stored none keeps wait; stop after stored cycle goes idle
        wr(A_CMD, cmd(0, 0, 0, 7'h00, 0, 0, 1), "R4");
        wr(A_CMD, cmd(0, 0, 4, 7'h00, 0, 0, 1), "R5");
        wr(A_PIN, 32'h1, "R2");
        wr(A_CMD, cmd(0, 0, 3, 7'h50, 5, 40, 1), "R4");
        wr(A_CMD, cmd(0, 0, 4, 7'h00, 0, 0, 1), "R5"); rd(A_STAT, "R5");
        rd(A_DATA, "R5");
        // R9: store boundary, wrong target, no monitor
        wr(A_PIN, 32'h1, "R2");
        wr(A_CMD, cmd(0, 0, 7, 7'h50, 8'hFE, 9'h104, 1), "R9"); rd(A_DATA, "R9");
        wr(A_PIN, 32'h1, "R2");
        wr(A_CMD, cmd(0, 0, 7, 7'h51, 0, 4, 1), "R9"); rd(A_DATA, "R9");
        wr(A_PIN, 32'h2, "R2");
        wr(A_CMD, cmd(0, 0, 7, 7'h50, 0, 4, 1), "R9"); rd(A_DATA, "R9");
        // R8: direction clear
        wr(A_PIN, 32'h1, "R2");
        wr(A_CMD, cmd(0, 0, 7, 7'h50, 0, 8, 0), "R8"); rd(A_DATA, "R8");
        // R12: data write ignored
        wr(A_DATA, 32'hDEAD_BEEF, "R12"); rd(A_DATA, "R12");

        // random mix
        for (int k = 0; k < 3000; k++) begin
            int op = int'($urandom % 12);
            if (op == 0) begin
                if ($urandom % 3 == 0) begin
                    mon_present = 4'($urandom); mon_is_dp = 4'($urandom);
                end
                wr(A_PIN, 32'($urandom % 8), "R2");
            end else if (op <= 2) begin
                wr(A_CMD, cmd(($urandom % 10) == 0, 1'($urandom), int'($urandom % 8),
                    ($urandom % 4 != 0) ? 7'h50 : 7'($urandom), int'($urandom % 256),
                    int'($urandom % 300), ($urandom % 6) != 0), "R4");
            end else if (op == 3) rd(A_STAT, "R3");
            else if (op == 4) wr(A_STAT, $urandom, "R3");
            else if (op == 5) rd(A_CMD, "R11");
            else if (op == 6) wr(A_DATA, $urandom, "R12");
            else rd(A_DATA, "R6");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule